// File: doc/BRIEF.md
# Tagged Split-Transaction Memory Port

This block is one port of a memory hub that splits each access into two phases. In the first phase a master presents a word address and a direction and holds its strobe until the hub acknowledges. With that acknowledge the hub hands back a small integer tag that names the transaction. In the second phase the hub calls a tag. The data then moves in the next bus cycle: read data goes back to the master, and write data plus byte masks come from the master. Each transfer takes exactly one cycle.

The port keeps a pool of tags and a first-in first-out record of the transactions in flight. A transaction becomes eligible for a call a fixed number of cycles after its issue, which stands in for memory latency. Calls go out oldest-first, at most one per cycle. A small word array inside the port holds the data, so the port can be exercised on its own. Several masters may share the write lines by OR-ing them, because the port reads those lines only in the cycle that follows a write call.

Top module: `tagged_mem_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ack` is 1, `call` is 0, `tag_issue` is 0 and `data_r` is 0.
- R2: `req_ack` is 1 in any cycle where at least one tag is free or is on `tag_call` with `call` high, whatever the level of `req_stb`. It is 0 when every tag is in flight and no call is made.
- R3: A request is taken at a rising edge where `req_stb` and `req_ack` are both 1. `tag_issue` is then the lowest-numbered tag that is free in that cycle.
- R4: A tag shown on `tag_call` in a cycle counts as free in that same cycle, so it can be issued again in that cycle.
- R5: `call` is 1 in a cycle exactly when the oldest uncalled transaction was taken at least MIN_LAT (default 4) cycles earlier, and `tag_call` then names that oldest transaction.
- R6: In the cycle after a read is called, `data_r` holds the word stored at that read's address.
- R7: In the cycle after a write is called, byte k of `data_w` (bits 8k+7 to 8k) is stored into the word at that write's address when `data_wm[k]` is 0. When `data_wm[k]` is 1, that byte keeps its old value.
- R8: `data_r` is 0 in any cycle that does not follow a read call, including the cycle after a write call.
- R9: A read that is called in the same cycle as the data of an earlier write to the same address returns the word with that write applied.
- R10: `data_w` and `data_wm` have no effect in cycles that do not follow a write call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_adr | input | ADR_W | Word address of the request |
| req_we | input | 1 | 1 for a write request, 0 for a read |
| req_stb | input | 1 | Request valid; held until acknowledged |
| req_ack | output | 1 | A tag is available; the request is taken at the edge |
| tag_issue | output | TAG_W | Tag handed out with the acknowledge |
| call | output | 1 | A transaction is called this cycle |
| tag_call | output | TAG_W | Tag of the called transaction |
| data_r | output | DATA_W | Read data, valid in the cycle after a read call |
| data_w | input | DATA_W | Write data, driven in the cycle after a write call |
| data_wm | input | DATA_W/8 | Byte masks for the write data, 0 writes the byte |

## Verification
Two pairs of events can land in the same cycle. A tag can be released by a call while a new request is acknowledged, and the freed tag can then be the one that is issued again. Write data for an address can also arrive in the same cycle that a read of that address is called. The stimulus keeps the strobe high most of the time so the tag pool runs dry, and it confines addresses to two words while mixing directions. In every cycle the bench derives the expected acknowledge and the lowest free tag from its own busy map, after it has freed the called tag. It also rebuilds the expected read word from a model that has already merged the write data arriving in that cycle.

// File: rtl/tagged_mem_port_pkg.sv
`timescale 1ns/1ps
package tagged_mem_port_pkg;
   typedef enum logic {
      XFER_RD = 1'b0,
      XFER_WR = 1'b1
   } xfer_e;
endpackage

// File: rtl/tmp_tag_pool.sv
`timescale 1ns/1ps
module tmp_tag_pool #(
   parameter int NUM_TAGS = 4,
   parameter int TAG_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                grant,
   input  logic                rel_vld,
   input  logic [TAG_W-1:0]    rel_tag,
   output logic                avail,
   output logic [TAG_W-1:0]    pick_tag,
   output logic [NUM_TAGS-1:0] busy_o
);
   logic [NUM_TAGS-1:0] busy_q;
   logic [NUM_TAGS-1:0] rel_vec;
   logic [NUM_TAGS-1:0] free_vec;
   logic [NUM_TAGS-1:0] pick_vec;
   logic [NUM_TAGS:0]   seen;

   always_comb begin
      rel_vec = '0;
      if (rel_vld) rel_vec[rel_tag] = 1'b1;
   end

   assign free_vec = ~busy_q | rel_vec;
   assign seen[0]  = 1'b0;

   generate
      for (genvar g = 0; g < NUM_TAGS; g++) begin : g_pick
         assign pick_vec[g] = free_vec[g] & ~seen[g];
         assign seen[g+1]   = seen[g] | free_vec[g];
      end
   endgenerate

   always_comb begin
      pick_tag = '0;
      for (int i = 0; i < NUM_TAGS; i++) begin
         if (pick_vec[i]) pick_tag = TAG_W'(i);
      end
   end

   assign avail  = seen[NUM_TAGS];
   assign busy_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else begin
         busy_q <= (busy_q & ~rel_vec) | (grant ? pick_vec : '0);
      end
   end
endmodule

// File: rtl/tmp_call_queue.sv
`timescale 1ns/1ps
module tmp_call_queue
   import tagged_mem_port_pkg::*;
#(
   parameter int DEPTH   = 4,
   parameter int TAG_W   = 2,
   parameter int ADR_W   = 4,
   parameter int MIN_LAT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [TAG_W-1:0] push_tag,
   input  logic [ADR_W-1:0] push_adr,
   input  xfer_e            push_kind,
   output logic             call_vld,
   output logic [TAG_W-1:0] call_tag,
   output logic [ADR_W-1:0] call_adr,
   output xfer_e            call_kind,
   output logic             full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int AGE_W = $clog2(MIN_LAT + 1);

   logic [TAG_W-1:0] tag_q  [DEPTH];
   logic [ADR_W-1:0] adr_q  [DEPTH];
   xfer_e            kind_q [DEPTH];
   logic [AGE_W-1:0] age_q  [DEPTH];
   logic [DEPTH-1:0] valid_q;
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic             pop;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign call_vld  = valid_q[rd_ptr_q] && (age_q[rd_ptr_q] >= AGE_W'(MIN_LAT));
   assign call_tag  = tag_q[rd_ptr_q];
   assign call_adr  = adr_q[rd_ptr_q];
   assign call_kind = kind_q[rd_ptr_q];
   assign full      = valid_q[wr_ptr_q];
   assign pop       = call_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
      end else begin
         if (push) wr_ptr_q <= step(wr_ptr_q);
         if (pop)  rd_ptr_q <= step(rd_ptr_q);
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q[g] <= 1'b0;
               age_q[g]   <= '0;
               tag_q[g]   <= '0;
               adr_q[g]   <= '0;
               kind_q[g]  <= XFER_RD;
            end else if (push && (wr_ptr_q == PTR_W'(g))) begin
               valid_q[g] <= 1'b1;
               age_q[g]   <= AGE_W'(1);
               tag_q[g]   <= push_tag;
               adr_q[g]   <= push_adr;
               kind_q[g]  <= push_kind;
            end else if (pop && (rd_ptr_q == PTR_W'(g))) begin
               valid_q[g] <= 1'b0;
            end else if (valid_q[g] && (age_q[g] < AGE_W'(MIN_LAT))) begin
               age_q[g]   <= age_q[g] + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tmp_data_store.sv
`timescale 1ns/1ps
module tmp_data_store #(
   parameter int ADR_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_go,
   input  logic                wr_go,
   input  logic [ADR_W-1:0]    go_adr,
   input  logic [DATA_W-1:0]   data_w,
   input  logic [DATA_W/8-1:0] data_wm,
   output logic [DATA_W-1:0]   data_r
);
   localparam int LANES = DATA_W / 8;
   localparam int WORDS = 1 << ADR_W;

   logic [DATA_W-1:0] mem_q [WORDS];
   logic              wr_pend_q;
   logic [ADR_W-1:0]  wr_adr_q;
   logic [DATA_W-1:0] rd_q;
   logic [DATA_W-1:0] old_word;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] rd_word;

   assign old_word = mem_q[wr_adr_q];

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign merged[8*l +: 8] = data_wm[l] ? old_word[8*l +: 8] : data_w[8*l +: 8];
      end
   endgenerate

   assign rd_word = (wr_pend_q && (wr_adr_q == go_adr)) ? merged : mem_q[go_adr];
   assign data_r  = rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pend_q <= 1'b0;
         wr_adr_q  <= '0;
         rd_q      <= '0;
         for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      end else begin
         wr_pend_q <= wr_go;
         if (wr_go) wr_adr_q <= go_adr;
         rd_q <= rd_go ? rd_word : '0;
         if (wr_pend_q) mem_q[wr_adr_q] <= merged;
      end
   end
endmodule

// File: rtl/tagged_mem_port.sv
`timescale 1ns/1ps
module tagged_mem_port
   import tagged_mem_port_pkg::*;
#(
   parameter int NUM_TAGS = 4,
   parameter int ADR_W    = 4,
   parameter int DATA_W   = 32,
   parameter int MIN_LAT  = 4,
   localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
   localparam int MASK_W  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADR_W-1:0]  req_adr,
   input  logic              req_we,
   input  logic              req_stb,
   output logic              req_ack,
   output logic [TAG_W-1:0]  tag_issue,
   output logic              call,
   output logic [TAG_W-1:0]  tag_call,
   output logic [DATA_W-1:0] data_r,
   input  logic [DATA_W-1:0] data_w,
   input  logic [MASK_W-1:0] data_wm
);
   generate
      if (NUM_TAGS < 2) begin : g_bad_tags
         $error("tagged_mem_port: NUM_TAGS must be at least 2");
      end
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
         $error("tagged_mem_port: DATA_W must be a positive multiple of 8");
      end
      if (MIN_LAT < 1) begin : g_bad_lat
         $error("tagged_mem_port: MIN_LAT must be at least 1");
      end
      if (ADR_W < 1 || ADR_W > 10) begin : g_bad_adr
         $error("tagged_mem_port: ADR_W out of range 1..10");
      end
   endgenerate

   logic                q_push;
   logic                q_full;
   logic [ADR_W-1:0]    call_adr;
   xfer_e               call_kind;
   logic                call_wr;
   logic [NUM_TAGS-1:0] busy_vec;

   assign q_push  = req_stb & req_ack;
   assign call_wr = (call_kind == XFER_WR);

   tmp_tag_pool #(
      .NUM_TAGS (NUM_TAGS),
      .TAG_W    (TAG_W)
   ) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant    (q_push),
      .rel_vld  (call),
      .rel_tag  (tag_call),
      .avail    (req_ack),
      .pick_tag (tag_issue),
      .busy_o   (busy_vec)
   );

   tmp_call_queue #(
      .DEPTH    (NUM_TAGS),
      .TAG_W    (TAG_W),
      .ADR_W    (ADR_W),
      .MIN_LAT  (MIN_LAT)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_tag  (tag_issue),
      .push_adr  (req_adr),
      .push_kind (req_we ? XFER_WR : XFER_RD),
      .call_vld  (call),
      .call_tag  (tag_call),
      .call_adr  (call_adr),
      .call_kind (call_kind),
      .full      (q_full)
   );

   tmp_data_store #(
      .ADR_W   (ADR_W),
      .DATA_W  (DATA_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_go   (call & ~call_wr),
      .wr_go   (call & call_wr),
      .go_adr  (call_adr),
      .data_w  (data_w),
      .data_wm (data_wm),
      .data_r  (data_r)
   );
endmodule

// File: rtl/tagged_mem_port_chk.sv
`timescale 1ns/1ps
module tagged_mem_port_chk #(
   parameter int NUM_TAGS = 4,
   parameter int TAG_W    = 2,
   parameter int DATA_W   = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_stb,
   input logic                req_ack,
   input logic [TAG_W-1:0]    tag_issue,
   input logic                call,
   input logic [TAG_W-1:0]    tag_call,
   input logic                call_wr,
   input logic [NUM_TAGS-1:0] busy_vec,
   input logic                q_push,
   input logic                q_full,
   input logic [DATA_W-1:0]   data_r
);
   AST_CALL_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      call |-> busy_vec[tag_call]);                                             // R5
   AST_ISSUE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_stb && req_ack && !(call && tag_call == tag_issue)) |-> !busy_vec[tag_issue]); // R3
   AST_FULL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ((&busy_vec) && !call) |-> !req_ack);                                    // R2
   AST_WR_NO_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (call && call_wr) |=> (data_r == '0));                                   // R8
   AST_REUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (call && req_stb && req_ack && tag_issue == tag_call) |=> busy_vec[$past(tag_call)]); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && !call) |-> !q_full);                                          // R2
endmodule

bind tagged_mem_port tagged_mem_port_chk #(
   .NUM_TAGS (NUM_TAGS),
   .TAG_W    (TAG_W),
   .DATA_W   (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_stb   (req_stb),
   .req_ack   (req_ack),
   .tag_issue (tag_issue),
   .call      (call),
   .tag_call  (tag_call),
   .call_wr   (call_wr),
   .busy_vec  (busy_vec),
   .q_push    (q_push),
   .q_full    (q_full),
   .data_r    (data_r)
);

// File: tb/sim_tagged_mem_port.sv
`timescale 1ns/1ps
module sim_tagged_mem_port;
   localparam int NT = 4;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam int ML = 4;
   localparam int MW = DW / 8;
   localparam int TW = 2;

   typedef struct {
      int            tag;
      int            adr;
      bit            we;
      logic [DW-1:0] d;
      logic [MW-1:0] m;
      int            cyc;
   } txn_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] req_adr = '0;
   logic          req_we = 1'b0;
   logic          req_stb = 1'b0;
   logic          req_ack;
   logic [TW-1:0] tag_issue;
   logic          call;
   logic [TW-1:0] tag_call;
   logic [DW-1:0] data_r;
   logic [DW-1:0] data_w = '0;
   logic [MW-1:0] data_wm = '0;

   int n_chk = 0;
   int n_fail = 0;

   tagged_mem_port #(
      .NUM_TAGS (NT), .ADR_W (AW), .DATA_W (DW), .MIN_LAT (ML)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .req_adr (req_adr), .req_we (req_we),
      .req_stb (req_stb), .req_ack (req_ack), .tag_issue (tag_issue),
      .call (call), .tag_call (tag_call), .data_r (data_r),
      .data_w (data_w), .data_wm (data_wm)
   );

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                           input logic [MW-1:0] m);
      logic [DW-1:0] r;
      r = old;
      for (int k = 0; k < MW; k++) if (!m[k]) r[8*k +: 8] = d[8*k +: 8];
      return r;
   endfunction

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      txn_t          fifo[$];
      txn_t          pend;
      bit            pend_v;
      bit            pend_fwd;
      logic [DW-1:0] pend_exp;
      bit            busyb [NT];
      logic [DW-1:0] model [1 << AW];
      int            cyc;
      int            wadr_now;
      bit            exp_call;
      bit            exp_ack;
      int            low;
      bit            took;

      void'($urandom(32'd20240611));
      for (int i = 0; i < NT; i++) busyb[i] = 1'b0;
      for (int i = 0; i < (1 << AW); i++) model[i] = '0;
      pend_v = 1'b0; pend_fwd = 1'b0; pend_exp = '0; took = 1'b0; cyc = 0;

      repeat (3) @(negedge clk);
      // R1: values while reset is held
      chk(req_ack == 1'b1 && call == 1'b0, "R1", {req_ack, call}, 2'b10);
      chk(tag_issue == '0 && data_r == '0, "R1", data_r, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ack == 1'b1 && call == 1'b0 && tag_issue == '0 && data_r == '0, "R1",
          {req_ack, call, tag_issue}, 4'b1000);

      for (int c = 0; c < 3700; c++) begin
         @(negedge clk);
         cyc++;
         // data phase for the call made in the previous cycle
         wadr_now = -1;
         if (pend_v && !pend.we)
            chk(data_r == pend_exp, pend_fwd ? "R9" : "R6,R7,R10", data_r, pend_exp);
         else
            chk(data_r == '0, "R8", data_r, 0);
         if (pend_v && pend.we) begin
            data_w  = pend.d;
            data_wm = pend.m;
            model[pend.adr] = merge(model[pend.adr], pend.d, pend.m);
            wadr_now = pend.adr;
         end else if ($urandom % 3 == 0) begin
            data_w  = $urandom;   // R10: stray values must not reach storage
            data_wm = '0;
         end else begin
            data_w  = '0;
            data_wm = '0;
         end

         // call phase
         exp_call = (fifo.size() > 0) && (cyc - fifo[0].cyc >= ML);
         chk(call == exp_call, "R5", call, exp_call);
         pend_v = 1'b0;
         if (call && exp_call) begin
            chk(tag_call == TW'(fifo[0].tag), "R5", tag_call, fifo[0].tag);
            pend = fifo.pop_front();
            pend_v = 1'b1;
            busyb[pend.tag] = 1'b0;
            pend_fwd = !pend.we && (pend.adr == wadr_now);
            pend_exp = model[pend.adr];
         end

         // request phase
         if (!req_stb || took) begin
            int prob;
            prob = (cyc < 1200) ? 85 : (cyc < 2400) ? 100 : (cyc < 3600) ? 30 : 0;
            req_stb = (($urandom % 100) < prob);
            req_we  = $urandom % 2;
            req_adr = (cyc >= 1200 && cyc < 2400) ? AW'(5 + ($urandom % 2)) : AW'($urandom);
         end
         low = -1;
         for (int i = NT - 1; i >= 0; i--) if (!busyb[i]) low = i;
         exp_ack = (low >= 0);
         chk(req_ack == exp_ack, "R2", req_ack, exp_ack);
         took = req_stb && req_ack;
         if (exp_ack) begin
            if (pend_v && low == pend.tag)
               chk(tag_issue == TW'(low), "R4", tag_issue, low);
            else
               chk(tag_issue == TW'(low), "R3", tag_issue, low);
         end
         if (took) begin
            txn_t t;
            t.tag = int'(tag_issue);
            t.adr = int'(req_adr);
            t.we  = req_we;
            t.d   = $urandom;
            t.m   = MW'($urandom);
            t.cyc = cyc;
            fifo.push_back(t);
            busyb[t.tag] = 1'b1;
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule